// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank Controller

This block is one bank of up to 32 general-purpose pins, controlled through a single-cycle memory-mapped port. The port has a byte address, write data, a write strobe and combinational read data. Each pin has an output data bit and a direction bit. Software never writes these bits directly. Dedicated set and clear registers change only the bits where the written data holds a one, so separate software threads can drive different pins without a read-modify-write race.

Inputs are brought into the clock domain through a synchronizer chain. The synchronized value is compared with its value one cycle earlier to find rising and falling edges. Each pin has two independent interrupt enables, one for rising edges and one for falling edges. An enabled edge sets a sticky pending bit, which software clears by writing a one to it. The bank ORs all pending bits into a single interrupt output for a higher-level controller.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, every output data bit and every direction bit is 0, so all pins are inputs. Both enable registers and the pending register read 0, and `irqOut` is low.
- R2: Offset 0x14 sets output data bits and offset 0x18 clears them. Only bits written as 1 change. `pinOut` shows the new value one cycle after the write edge.
- R3: Offset 0x1C sets direction bits and offset 0x20 clears them. Only bits written as 1 change. A direction bit of 1 makes the pin an output. The direction vector appears on `pinOutEn` and reads back at offset 0x04. Writes to offset 0x04 are ignored.
- R4: Offset 0x00 reads the synchronized input value. A change on `pinIn` becomes readable after two clock edges and not after one.
- R5: The rising-edge enable register at offset 0x28 and the falling-edge enable register at offset 0x2C are plain read/write registers, one bit per pin.
- R6: A pin's pending bit is set on the third clock edge after its input changes. It is set only for a 0-to-1 change while the pin's rising enable is 1, or a 1-to-0 change while its falling enable is 1. Edges with the matching enable at 0 set nothing.
- R7: Offset 0x0C reads the pending bits. Writing a 1 to a bit clears it, and writing a 0 leaves it as it was. Pending bits never clear without such a write.
- R8: If an enabled edge sets a pending bit on the same clock edge that a clear write targets that bit, the bit ends up set.
- R9: `irqOut` is high exactly when at least one pending bit is set.
- R10: Bits at or above `NUM_PINS` read 0 and ignore writes. Reads return 0 at every offset other than 0x00, 0x04, 0x0C, 0x28 and 0x2C, including the write-only set and clear offsets and any address not aligned to 4 bytes. Writes to undefined offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrData | input | 32 | Write data |
| busWrEn | input | 1 | Write strobe, acted on at the clock edge |
| busRdData | output | 32 | Combinational read data for `busAddr` |
| pinIn | input | NUM_PINS | Asynchronous pin input levels |
| pinOut | output | NUM_PINS | Output data per pin |
| pinOutEn | output | NUM_PINS | Direction per pin, 1 = output |
| irqOut | output | 1 | Aggregate bank interrupt |

## Verification
Register writes take effect at the write edge. Set, clear and enable results are therefore sampled on the falling edge after that edge, and read data is sampled 1 ns after the address settles because the read path has no register. An input change is due at offset 0x00 after two rising edges, and the bench also checks once that the old value is still present after only one. A pending bit and `irqOut` are due after three rising edges, so every edge scenario waits exactly three edges before sampling. The same-cycle clear case places the clear write on precisely that third edge.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  // Word indices (byte offset / 4) of the register map.
  localparam int WORD_IN    = 0;   // 0x00
  localparam int WORD_OE    = 1;   // 0x04
  localparam int WORD_PEND  = 3;   // 0x0C
  localparam int WORD_OSET  = 5;   // 0x14
  localparam int WORD_OCLR  = 6;   // 0x18
  localparam int WORD_OESET = 7;   // 0x1C
  localparam int WORD_OECLR = 8;   // 0x20
  localparam int WORD_RISE  = 10;  // 0x28
  localparam int WORD_FALL  = 11;  // 0x2C

  typedef enum logic [2:0] {
    RD_NONE,
    RD_IN,
    RD_OE,
    RD_PEND,
    RD_RISE,
    RD_FALL
  } rdSel_e;

  typedef struct packed {
    logic   outSet;
    logic   outClr;
    logic   oeSet;
    logic   oeClr;
    logic   riseWr;
    logic   fallWr;
    logic   pendAck;
    rdSel_e rdSel;
  } bankStrobe_t;

endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output bankStrobe_t       strobe
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              aligned;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_NONE;
    if (aligned) begin
      case (32'(wordIdx))
        WORD_IN:    strobe.rdSel   = RD_IN;
        WORD_OE:    strobe.rdSel   = RD_OE;
        WORD_PEND:  begin
          strobe.rdSel   = RD_PEND;
          strobe.pendAck = busWrEn;
        end
        WORD_OSET:  strobe.outSet  = busWrEn;
        WORD_OCLR:  strobe.outClr  = busWrEn;
        WORD_OESET: strobe.oeSet   = busWrEn;
        WORD_OECLR: strobe.oeClr   = busWrEn;
        WORD_RISE:  begin
          strobe.rdSel  = RD_RISE;
          strobe.riseWr = busWrEn;
        end
        WORD_FALL:  begin
          strobe.rdSel  = RD_FALL;
          strobe.fallWr = busWrEn;
        end
        default:    strobe.rdSel   = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else        stage[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else        stage[s] <= stage[s-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/gpio_edge_dp.sv
module gpio_edge_dp
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  bankStrobe_t         strobe,
  input  logic [31:0]         wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOutEn,
  output logic [NUM_PINS-1:0] pendVec,
  output logic                irqOut,
  output logic [31:0]         rdData
);

  logic [NUM_PINS-1:0] wrBits;
  logic [NUM_PINS-1:0] outReg;
  logic [NUM_PINS-1:0] oeReg;
  logic [NUM_PINS-1:0] riseEn;
  logic [NUM_PINS-1:0] fallEn;
  logic [NUM_PINS-1:0] syncVal;
  logic [NUM_PINS-1:0] prevVal;
  logic [NUM_PINS-1:0] riseHit;
  logic [NUM_PINS-1:0] fallHit;
  logic [NUM_PINS-1:0] pendReg;
  logic [NUM_PINS-1:0] rdSelVec;

  assign wrBits = wrData[NUM_PINS-1:0];

  // Output data: write-one-to-set / write-one-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             outReg <= '0;
    else if (strobe.outSet) outReg <= outReg | wrBits;
    else if (strobe.outClr) outReg <= outReg & ~wrBits;
  end

  // Direction: write-one-to-set / write-one-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            oeReg <= '0;
    else if (strobe.oeSet) oeReg <= oeReg | wrBits;
    else if (strobe.oeClr) oeReg <= oeReg & ~wrBits;
  end

  // Edge enables: plain read/write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      riseEn <= '0;
      fallEn <= '0;
    end else begin
      if (strobe.riseWr) riseEn <= wrBits;
      if (strobe.fallWr) fallEn <= wrBits;
    end
  end

  gpio_edge_sync #(
    .WIDTH (NUM_PINS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pinIn),
    .dout (syncVal)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevVal <= '0;
    else        prevVal <= syncVal;
  end

  assign riseHit = syncVal & ~prevVal & riseEn;
  assign fallHit = ~syncVal & prevVal & fallEn;

  // Per-pin sticky pending flag; a new edge beats a same-cycle clear.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pend
    logic ackBit;
    assign ackBit = strobe.pendAck & wrBits[p];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      pendReg[p] <= 1'b0;
      else if (riseHit[p] | fallHit[p]) pendReg[p] <= 1'b1;
      else if (ackBit)                 pendReg[p] <= 1'b0;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RD_IN:   rdSelVec = syncVal;
      RD_OE:   rdSelVec = oeReg;
      RD_PEND: rdSelVec = pendReg;
      RD_RISE: rdSelVec = riseEn;
      RD_FALL: rdSelVec = fallEn;
      default: rdSelVec = '0;
    endcase
    rdData                 = '0;
    rdData[NUM_PINS-1:0]   = rdSelVec;
  end

  assign pinOut   = outReg;
  assign pinOutEn = oeReg;
  assign pendVec  = pendReg;
  assign irqOut   = |pendReg;

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWrData,
  input  logic                busWrEn,
  output logic [31:0]         busRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOutEn,
  output logic                irqOut
);

  bankStrobe_t         strobe;
  logic [NUM_PINS-1:0] pendVec;

  gpio_edge_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strobe (strobe)
  );

  gpio_edge_dp #(
    .NUM_PINS   (NUM_PINS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .wrData  (busWrData),
    .pinIn   (pinIn),
    .pinOut  (pinOut),
    .pinOutEn(pinOutEn),
    .pendVec (pendVec),
    .irqOut  (irqOut),
    .rdData  (busRdData)
  );

endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [31:0]         busWrData,
  input logic                busWrEn,
  input logic [31:0]         busRdData,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] pinOutEn,
  input logic [NUM_PINS-1:0] pendVec,
  input logic                irqOut
);

  logic [31:0] wordNum;
  logic        alignedAcc;
  logic        readable;

  assign wordNum    = 32'(busAddr[ADDR_W-1:2]);
  assign alignedAcc = (busAddr[1:0] == 2'b00);
  assign readable   = alignedAcc && (wordNum == WORD_IN || wordNum == WORD_OE ||
                      wordNum == WORD_PEND || wordNum == WORD_RISE || wordNum == WORD_FALL);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pinOut == '0 && pinOutEn == '0 && !irqOut));

  assert_out_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && alignedAcc && wordNum == WORD_OSET)
      |=> pinOut == ($past(pinOut) | $past(busWrData[NUM_PINS-1:0])));

  assert_oe_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && alignedAcc && wordNum == WORD_OECLR)
      |=> pinOutEn == ($past(pinOutEn) & ~$past(busWrData[NUM_PINS-1:0])));

  assert_pend_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busWrEn && alignedAcc && wordNum == WORD_PEND)
      |=> ((pendVec & $past(pendVec)) == $past(pendVec)));

  assert_irq_any_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut == (pendVec != '0));

  assert_undef_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !readable |-> busRdData == 32'd0);

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(
  .NUM_PINS(NUM_PINS),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busAddr  (busAddr),
  .busWrData(busWrData),
  .busWrEn  (busWrEn),
  .busRdData(busRdData),
  .pinOut   (pinOut),
  .pinOutEn (pinOutEn),
  .pendVec  (pendVec),
  .irqOut   (irqOut)
);

// File: tb/gpio_edge_bank_bench.sv
module gpio_edge_bank_bench;

  localparam int NP     = 8;
  localparam int AW     = 8;
  localparam logic [31:0] PMASK = 32'h0000_00FF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWrData = '0;
  logic          busWrEn = 1'b0;
  logic [31:0]   busRdData;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] pinOut;
  logic [NP-1:0] pinOutEn;
  logic          irqOut;

  int total = 0;
  int bad = 0;
  logic [31:0] rdVal;
  logic [31:0] outModel;
  logic [31:0] oeModel;

  always #4 clk = ~clk;

  gpio_edge_bank #(
    .NUM_PINS(NP),
    .ADDR_W  (AW)
  ) u_gpio_edge_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .busWrEn  (busWrEn),
    .busRdData(busRdData),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOutEn (pinOutEn),
    .irqOut   (irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busAddr   = a;
    busWrData = d;
    busWrEn   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn   = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a);
    busAddr = a;
    #1;
    rdVal = busRdData;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ticks(3);
    rst_n = 1'b1;
    ticks(1);

    // R1 reset state
    check("R1 pinOut", 32'(pinOut), 0);
    check("R1 pinOutEn", 32'(pinOutEn), 0);
    check("R1 irqOut", 32'(irqOut), 0);
    busRead(8'h04); check("R1 oe read", rdVal, 0);
    busRead(8'h0C); check("R1 pend read", rdVal, 0);
    busRead(8'h28); check("R1 rise read", rdVal, 0);
    busRead(8'h2C); check("R1 fall read", rdVal, 0);

    // R2 output set/clear sweep, upper write bits are junk
    outModel = 0;
    for (int i = 0; i < 48; i++) begin
      logic [31:0] d;
      d = 32'(i * 53 + 17) | 32'hA5A5_0000;
      if (i % 2 == 0) begin
        busWrite(8'h14, d);
        outModel = outModel | (d & PMASK);
      end else begin
        busWrite(8'h18, d);
        outModel = outModel & ~d & PMASK;
      end
      check("R2 pinOut", 32'(pinOut), outModel);
    end
    busWrite(8'h14, 32'hFFFF_FFFF);
    check("R2 set all", 32'(pinOut), PMASK);
    busWrite(8'h18, 32'h0000_0000);
    check("R2 clear zero no effect", 32'(pinOut), PMASK);
    busWrite(8'h18, 32'h0000_0081);
    check("R2 clear two", 32'(pinOut), 32'h7E);
    outModel = 32'h7E;

    // R3 direction set/clear sweep with readback
    oeModel = 0;
    for (int i = 0; i < 48; i++) begin
      logic [31:0] d;
      d = 32'(i * 29 + 3) | 32'h5A00_0000;
      if (i % 3 != 2) begin
        busWrite(8'h1C, d);
        oeModel = oeModel | (d & PMASK);
      end else begin
        busWrite(8'h20, d);
        oeModel = oeModel & ~d & PMASK;
      end
      check("R3 pinOutEn", 32'(pinOutEn), oeModel);
      busRead(8'h04);
      check("R3 oe readback", rdVal, oeModel);
    end
    busWrite(8'h04, 32'h0000_0000);
    check("R3 write to 0x04 ignored", 32'(pinOutEn), oeModel);
    check("R2 out untouched by oe writes", 32'(pinOut), outModel);

    // R4 input value sweep over every pattern
    for (int v = 0; v < 256; v++) begin
      pinIn = NP'(v);
      ticks(1);
      if (v == 8'hA5) begin
        busRead(8'h00);
        check("R4 one edge still old", rdVal, 32'hA4);
      end
      ticks(1);
      busRead(8'h00);
      check("R4 input read", rdVal, 32'(v));
    end
    pinIn = '0;
    ticks(4);
    busRead(8'h0C);
    check("R6 no pending with enables off", rdVal, 0);

    // R5 enable registers read/write
    busWrite(8'h28, 32'hDEAD_BE3C);
    busRead(8'h28); check("R5 rise rw", rdVal, 32'h3C);
    busWrite(8'h2C, 32'h1234_56C3);
    busRead(8'h2C); check("R5 fall rw", rdVal, 32'hC3);
    busRead(8'h28); check("R5 rise independent", rdVal, 32'h3C);

    // R6/R7/R9 per-pin edge sweep
    for (int p = 0; p < NP; p++) begin
      logic [31:0] m;
      m = 32'(1) << p;
      busWrite(8'h28, m);
      busWrite(8'h2C, 0);
      pinIn = NP'(m);
      ticks(2);
      busRead(8'h0C); check("R6 not yet after two edges", rdVal, 0);
      ticks(1);
      busRead(8'h0C); check("R6 rise sets pending", rdVal, m);
      check("R9 irq high", 32'(irqOut), 1);
      busWrite(8'h0C, ~m);
      busRead(8'h0C); check("R7 zero bits keep pending", rdVal, m);
      busWrite(8'h0C, m);
      busRead(8'h0C); check("R7 one clears pending", rdVal, 0);
      check("R9 irq low", 32'(irqOut), 0);
      pinIn = '0;
      ticks(3);
      busRead(8'h0C); check("R6 fall disabled", rdVal, 0);
      busWrite(8'h28, 0);
      busWrite(8'h2C, m);
      pinIn = NP'(m);
      ticks(3);
      busRead(8'h0C); check("R6 rise disabled", rdVal, 0);
      pinIn = '0;
      ticks(3);
      busRead(8'h0C); check("R6 fall sets pending", rdVal, m);
      busWrite(8'h0C, 32'hFFFF_FFFF);
      busRead(8'h0C); check("R7 clear all", rdVal, 0);
    end

    // R8 set wins over a same-edge clear
    busWrite(8'h28, 32'h10);
    busWrite(8'h2C, 32'h10);
    pinIn = 8'h10;
    ticks(3);
    busRead(8'h0C); check("R8 precondition", rdVal, 32'h10);
    pinIn = 8'h00;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    busWrite(8'h0C, 32'h10);
    busRead(8'h0C); check("R8 set wins", rdVal, 32'h10);
    check("R8 irq stays", 32'(irqOut), 1);
    busWrite(8'h0C, 32'h10);
    busRead(8'h0C); check("R8 later clear", rdVal, 0);

    // R10 undefined offsets and unaligned addresses
    busWrite(8'h28, 32'hFF);
    busRead(8'h08); check("R10 0x08", rdVal, 0);
    busRead(8'h10); check("R10 0x10", rdVal, 0);
    busRead(8'h14); check("R10 set offset reads 0", rdVal, 0);
    busRead(8'h24); check("R10 0x24", rdVal, 0);
    busRead(8'h29); check("R10 unaligned", rdVal, 0);
    busRead(8'h3C); check("R10 0x3C", rdVal, 0);
    busWrite(8'h15, 32'hFF);
    check("R10 unaligned write ignored", 32'(pinOut), outModel);
    busWrite(8'h24, 32'hFF);
    check("R10 undefined write ignored", 32'(pinOutEn), oeModel);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule